// File: doc/BRIEF.md
# Bus Data Parity Generator/Checker

This block protects a 64-bit processor data bus with one parity bit per byte lane. It watches the bus data, the active-low data-bus-busy strobe, the active-low transfer-acknowledge strobe, and a two-bit role input. The role input says whether the local unit is master or slave in the current transfer and whether that transfer is a read or a write.

The role decides the block's job. When the unit is the data source (master write, slave read), the block drives odd parity for every byte lane and asserts a parity output-enable. A master write qualifies with data-bus-busy and a slave read qualifies with transfer-acknowledge. When the unit is the data sink (master read, slave write), the block compares the received parity bits against parity it computes from the data, but only on cycles with transfer-acknowledge asserted. A mismatch gives a one-cycle error pulse and a mask of the failing lanes. All outputs are registered, so each result appears one clock after the inputs it was computed from.

Top module: `bus_parity_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it, `par_out`, `par_oe`, `err_pulse` and `err_lanes` are all zero.
- R2: Lane i covers `bus_data[8i+7:8i]`. Its parity bit is odd: the eight data bits plus the parity bit hold an odd number of ones.
- R3: Role encoding: `mode[1]` set means master and `mode[0]` set means write. In a master write (`mode`=2'b11), a clock edge that samples `dbb_n` low gives `par_oe`=1 and `par_out` equal to the lane parity of the sampled data. `ta_n` plays no part in this.
- R4: In a slave read (`mode`=2'b00), a clock edge that samples `ta_n` low gives `par_oe`=1 and `par_out` equal to the lane parity of the sampled data. `dbb_n` plays no part in this.
- R5: On every edge that does not meet R3 or R4, `par_oe` becomes 0 and `par_out` becomes all zeros.
- R6: In a master read (2'b10) or slave write (2'b01), an edge that samples `ta_n` low sets bit i of `err_lanes` exactly when `par_in[i]` differs from the odd parity of lane i.
- R7: `err_pulse` is high exactly when `err_lanes` is nonzero. It is a one-cycle pulse for each sampled acknowledge that has a mismatch.
- R8: No check takes place when `ta_n` is sampled high, or when the role is master write or slave read. In those cases `err_pulse` and `err_lanes` become zero, whatever the parity input holds.
- R9: Every output reflects the inputs sampled at the preceding rising clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 64 | Data bus value (driven or received) |
| par_in | input | 8 | Received parity bits, one per lane |
| dbb_n | input | 1 | Data-bus-busy strobe, active low |
| ta_n | input | 1 | Transfer-acknowledge strobe, active low |
| mode | input | 2 | Role: bit 1 master, bit 0 write |
| par_out | output | 8 | Generated odd parity per lane |
| par_oe | output | 1 | Parity output-enable |
| err_pulse | output | 1 | One-cycle parity error pulse |
| err_lanes | output | 8 | Mask of failing lanes |

## Verification
Every output is due exactly one rising edge after the inputs that produce it. A behavioural model in the bench computes the expected generated parity, enable, error mask and pulse at that same rising edge. The outputs are compared at the following falling edge, and new inputs are applied only after that comparison, so every sample lines up with the single register stage. Directed patterns exercise each role with strobes asserted and released, corrupted lanes, and all-zero and all-one data. A long pseudo-random run then covers mixed strobe and role sequences.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;
  typedef enum logic [1:0] {
    ROLE_SLV_RD = 2'b00,
    ROLE_SLV_WR = 2'b01,
    ROLE_MST_RD = 2'b10,
    ROLE_MST_WR = 2'b11
  } role_e;
endpackage

// File: rtl/bpu_lane_parity.sv
module bpu_lane_parity #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  odd_par
);
  // Odd parity: the bit that makes the lane plus parity hold an odd count of ones.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign odd_par[i] = ~(^data[i*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/bpu_role_decode.sv
module bpu_role_decode
  import bus_parity_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       dbb_n,
  input  logic       ta_n,
  output logic       src_cycle,
  output logic       chk_cycle
);
  role_e role;
  assign role = role_e'(mode);

  always_comb begin
    src_cycle = 1'b0;
    chk_cycle = 1'b0;
    unique case (role)
      ROLE_MST_WR: src_cycle = ~dbb_n;
      ROLE_SLV_RD: src_cycle = ~ta_n;
      ROLE_MST_RD,
      ROLE_SLV_WR: chk_cycle = ~ta_n;
      default: ;
    endcase
  end
endmodule

// File: rtl/bpu_gen.sv
module bpu_gen #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             src_cycle,
  input  logic [LANES-1:0] lane_par,
  output logic [LANES-1:0] par_out,
  output logic             par_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      par_out <= '0;
      par_oe  <= 1'b0;
    end else begin
      par_oe  <= src_cycle;
      par_out <= src_cycle ? lane_par : '0;
    end
  end

  AST_RELEASED_ZERO: assert property (@(posedge clk) disable iff (rst)
    !par_oe |-> (par_out == '0)); // R5
endmodule

// File: rtl/bpu_chk.sv
module bpu_chk #(
  parameter int LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_cycle,
  input  logic [LANES-1:0] lane_par,
  input  logic [LANES-1:0] par_in,
  output logic             err_pulse,
  output logic [LANES-1:0] err_lanes
);
  logic [LANES-1:0] mism;
  assign mism = chk_cycle ? (lane_par ^ par_in) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_lanes <= '0;
    end else begin
      err_pulse <= |mism;
      err_lanes <= mism;
    end
  end

  AST_PULSE_MATCHES_MASK: assert property (@(posedge clk) disable iff (rst)
    err_pulse == (err_lanes != '0)); // R7
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import bus_parity_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [LANES-1:0]  par_in,
  input  logic              dbb_n,
  input  logic              ta_n,
  input  logic [1:0]        mode,
  output logic [LANES-1:0]  par_out,
  output logic              par_oe,
  output logic              err_pulse,
  output logic [LANES-1:0]  err_lanes
);
  logic [LANES-1:0] lane_par;
  logic             src_cycle;
  logic             chk_cycle;

  // One parity tree serves both generation and checking.
  bpu_lane_parity #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_tree (
    .data    (bus_data),
    .odd_par (lane_par)
  );

  bpu_role_decode u_role (
    .mode      (mode),
    .dbb_n     (dbb_n),
    .ta_n      (ta_n),
    .src_cycle (src_cycle),
    .chk_cycle (chk_cycle)
  );

  bpu_gen #(.LANES(LANES)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .src_cycle (src_cycle),
    .lane_par  (lane_par),
    .par_out   (par_out),
    .par_oe    (par_oe)
  );

  bpu_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .chk_cycle (chk_cycle),
    .lane_par  (lane_par),
    .par_in    (par_in),
    .err_pulse (err_pulse),
    .err_lanes (err_lanes)
  );

  AST_SRC_CHK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(par_oe && err_pulse)); // R8

  AST_NO_CHECK_TA_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ta_n)) |-> !err_pulse); // R8

  AST_MW_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == 2'b11) && !$past(dbb_n)) |-> par_oe); // R3

  AST_SR_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == 2'b00) && !$past(ta_n)) |-> par_oe); // R4

  for (genvar i = 0; i < LANES; i++) begin : g_odd_chk
    AST_GEN_ODD: assert property (@(posedge clk) disable iff (rst)
      par_oe |-> (^{$past(bus_data[i*LANE_W +: LANE_W]), par_out[i]}) == 1'b1); // R2
  end
endmodule

// File: tb/bus_parity_unit_tb.sv
`timescale 1ns/1ps
module bus_parity_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] bus_data;
  logic [7:0]  par_in;
  logic        dbb_n;
  logic        ta_n;
  logic [1:0]  mode;
  logic [7:0]  par_out;
  logic        par_oe;
  logic        err_pulse;
  logic [7:0]  err_lanes;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_parity_unit u_dut (
    .clk(clk), .rst(rst), .bus_data(bus_data), .par_in(par_in),
    .dbb_n(dbb_n), .ta_n(ta_n), .mode(mode),
    .par_out(par_out), .par_oe(par_oe),
    .err_pulse(err_pulse), .err_lanes(err_lanes)
  );

  function automatic logic [7:0] ref_par(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) begin
      int ones;
      ones = $countones(d[i*8 +: 8]);
      p[i] = (ones % 2 == 0) ? 1'b1 : 1'b0;
    end
    return p;
  endfunction

  // Reference model: expected outputs computed at the rising edge
  logic [7:0] e_par, e_mask;
  logic       e_oe, e_err;
  string      gen_tag, chk_tag;

  always @(posedge clk) begin
    if (rst) begin
      e_par = 8'h00; e_oe = 0; e_mask = 8'h00; e_err = 0;
      gen_tag = "R1"; chk_tag = "R1";
    end else begin
      bit src, chk;
      src = (mode == 2'b11 && !dbb_n) || (mode == 2'b00 && !ta_n);
      chk = (mode == 2'b10 || mode == 2'b01) && !ta_n;
      e_oe  = src;
      e_par = src ? ref_par(bus_data) : 8'h00;
      e_mask = chk ? (par_in ^ ref_par(bus_data)) : 8'h00;
      e_err = (e_mask != 0);
      if (src && mode == 2'b11) gen_tag = "R3 R2 R9";
      else if (src) gen_tag = "R4 R2 R9";
      else gen_tag = "R5 R9";
      if (chk) chk_tag = e_err ? "R6 R7 R9" : "R6 R9";
      else chk_tag = "R8 R9";
    end
  end

  always @(negedge clk) begin
    if (!done && e_oe !== 1'bx) begin
      checks++;
      if (par_oe !== e_oe || par_out !== e_par) begin
        failures++;
        $display("FAIL %s: par_oe=%0b par_out=%02h expected par_oe=%0b par_out=%02h",
                 gen_tag, par_oe, par_out, e_oe, e_par);
      end
      checks++;
      if (err_pulse !== e_err || err_lanes !== e_mask) begin
        failures++;
        $display("FAIL %s: err_pulse=%0b err_lanes=%02h expected err_pulse=%0b err_lanes=%02h",
                 chk_tag, err_pulse, err_lanes, e_err, e_mask);
      end
    end
  end

  task automatic apply(input logic [1:0] m, input logic dbb, input logic ta,
                       input logic [63:0] d, input logic [7:0] corrupt);
    @(negedge clk);
    #0.1;
    mode = m; dbb_n = dbb; ta_n = ta; bus_data = d;
    par_in = ref_par(d) ^ corrupt;
  endtask

  initial begin
    rst = 1'b1; mode = 2'b11; dbb_n = 1'b0; ta_n = 1'b0;
    bus_data = 64'h0123_4567_89AB_CDEF; par_in = 8'h00;
    repeat (4) @(negedge clk);
    #0.1 rst = 1'b0;
    // directed cases
    apply(2'b11, 1'b0, 1'b1, 64'h0000_0000_0000_0000, 8'h00); // R3 all zero
    apply(2'b11, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h5A); // R3, R8 no check
    apply(2'b11, 1'b1, 1'b0, 64'h1234_5678_9ABC_DEF0, 8'h00); // R5 busy idle
    apply(2'b00, 1'b1, 1'b0, 64'h8001_0203_0405_0607, 8'h00); // R4
    apply(2'b00, 1'b0, 1'b1, 64'h8001_0203_0405_0607, 8'h00); // R5
    apply(2'b10, 1'b0, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 8'h00); // R6 clean
    apply(2'b10, 1'b0, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 8'h81); // R6 R7
    apply(2'b01, 1'b1, 1'b0, 64'h0F0F_0F0F_F0F0_F0F0, 8'hFF); // R6 all lanes
    apply(2'b01, 1'b0, 1'b1, 64'h0F0F_0F0F_F0F0_F0F0, 8'hFF); // R8 ta high
    apply(2'b10, 1'b0, 1'b0, 64'h0000_0000_0000_0001, 8'h01); // R6 single lane
    apply(2'b10, 1'b0, 1'b0, 64'h0000_0000_0000_0001, 8'h01); // R7 back to back
    // pseudo-random
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] c;
      c = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      apply(2'($urandom), 1'($urandom), 1'($urandom),
            {$urandom, $urandom}, c);
    end
    // reset mid-run
    apply(2'b11, 1'b0, 1'b0, 64'h1111_2222_3333_4444, 8'h00);
    @(negedge clk); #0.1 rst = 1'b1; // R1
    @(negedge clk); @(negedge clk); #0.1 rst = 1'b0;
    apply(2'b00, 1'b1, 1'b1, 64'h0, 8'h00);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule